// File: doc/BRIEF.md
# Sector Single-Bit Error Correcting Code Engine

This block computes a 24-bit Hamming-style check code over a data sector while the sector streams past, one byte per clock. Every byte carries a line address, its position in the sector, and a byte parity. Every data bit also has a fixed position, 0 to 7. From these the block keeps two 12-bit parity fields. The upper field collects the parities of the odd positions, where an address or bit-index bit is one. The lower field collects the even positions, where that bit is zero. At the end of the sector the two fields are joined and inverted. The inversion means an erased sector, with every byte at 0xFF, yields the all-ones code, and so it checks clean against the all-ones spare area.

The code is written as three bytes, least significant byte first. On a read, the code held in storage is applied at the stored-code input. The block XORs it with the freshly computed code and classifies the result:
- no error;
- a correctable single data-bit error, reported with the byte offset and bit index to flip;
- a single-bit error inside the stored code itself;
- an uncorrectable error.

The block only reports the fix. It does not apply it to a data buffer.

Top module: `sector_hamming_ecc`

## Requirements
- R1: When `byte_vld_i` is high, one byte is accepted per clock. After the byte that completes a sector (SECTOR_BYTES bytes, default 512) is accepted, `done_o` is high for exactly one cycle. At that same edge `code_o` takes the new code and holds it until the next sector completes.
- R2: Let the data bit at byte address a (9 bits) and bit index b (3 bits) be set. Each such bit toggles H by {a,b} and toggles L by ~{a,b}. The result is `code_o` = ~{H,L}, where H is in bits 23:12 and L is in bits 11:0. Bits 7:0 of `code_o` are the first byte to be stored, and bits 23:16 are the last.
- R3: A sector made only of 0xFF bytes produces the code 24'hFFFFFF.
- R4: Let d = `stored_code_i` XOR `code_o`. When d is zero, `status_o` is 0 (clean).
- R5: When d[23:12] XOR d[11:0] equals 12'hFFF and d[23:15] is below SECTOR_BYTES, `status_o` is 1 (data corrected). In that case `err_off_o` = d[23:15] and `err_bit_o` = d[14:12]. In every other status both of these outputs are zero.
- R6: When exactly one bit of d is set, `status_o` is 2 (error in the stored code only).
- R7: Any other non-zero d gives `status_o` 3 (uncorrectable).
- R8: When the halves of d are complements but d[23:15] is not below SECTOR_BYTES, `status_o` is 3.
- R9: `sof_i` clears the accumulation. A byte that is valid in the same cycle as `sof_i` counts as byte 0. Cycles with `byte_vld_i` low change nothing.
- R10: After reset, `done_o` is 0 and `code_o` is 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start of sector; clears the running parities |
| byte_vld_i | input | 1 | `byte_i` holds a sector byte this cycle |
| byte_i | input | 8 | Sector data byte |
| stored_code_i | input | 24 | Code read back from storage |
| code_o | output | 24 | Code of the last completed sector, byte 0 in bits 7:0 |
| done_o | output | 1 | One-cycle pulse after a sector completes |
| status_o | output | 2 | 0 clean, 1 data corrected, 2 code-only error, 3 uncorrectable |
| err_off_o | output | 9 | Byte offset to flip when status is 1 |
| err_bit_o | output | 3 | Bit index to flip when status is 1 |

## Verification
The assertions check the classification rules on every cycle:
- a clean status whenever the two codes match;
- complementary halves whenever data correction is reported;
- exactly one differing bit for a code-only error;
- zero location outputs outside status 1;
- a one-cycle `done_o` pulse;
- `code_o` holding between completions.

Only the bench scenarios can show that the code value itself is right. The bench compares it against an independent per-bit model over erased, patterned and gapped sectors. It also covers restart by `sof_i` in mid-sector and the out-of-range offset case, which is reachable only with a sector shorter than 512 bytes.

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc #(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic [23:0] stored_code_i,
  output logic [23:0] code_o,
  output logic        done_o,
  output logic [1:0]  status_o,
  output logic [8:0]  err_off_o,
  output logic [2:0]  err_bit_o
);
  localparam int AW = 9;
  localparam logic [AW-1:0] LAST = AW'(SECTOR_BYTES - 1);
  localparam logic [1:0] ST_CLEAN = 2'd0, ST_FIXED = 2'd1, ST_CODE = 2'd2, ST_BAD = 2'd3;

  logic [AW-1:0] cnt_q, addr;
  logic [11:0]   hi_q, lo_q, hi_n, lo_n;
  logic [23:0]   code_q, diff;
  logic          done_q, last, par, cmpl, in_range;

  assign par  = ^byte_i;
  assign addr = sof_i ? '0 : cnt_q;
  assign last = byte_vld_i && (addr == LAST);

  assign hi_n = (sof_i ? 12'h000 : hi_q) ^
                {addr & {AW{par}}, ^(byte_i & 8'hF0), ^(byte_i & 8'hCC), ^(byte_i & 8'hAA)};
  assign lo_n = (sof_i ? 12'h000 : lo_q) ^
                {~addr & {AW{par}}, ^(byte_i & 8'h0F), ^(byte_i & 8'h33), ^(byte_i & 8'h55)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      code_q <= 24'hFFFFFF;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (byte_vld_i) begin
        if (last) begin
          cnt_q  <= '0;
          hi_q   <= '0;
          lo_q   <= '0;
          code_q <= ~{hi_n, lo_n};
        end else begin
          cnt_q <= addr + 1'b1;
          hi_q  <= hi_n;
          lo_q  <= lo_n;
        end
      end else if (sof_i) begin
        cnt_q <= '0;
        hi_q  <= '0;
        lo_q  <= '0;
      end
    end
  end

  assign code_o   = code_q;
  assign done_o   = done_q;
  assign diff     = stored_code_i ^ code_q;
  assign cmpl     = (diff[23:12] ^ diff[11:0]) == 12'hFFF;
  assign in_range = 32'(diff[23:15]) < SECTOR_BYTES;

  always_comb begin
    if (diff == 24'h0)                   status_o = ST_CLEAN;
    else if (cmpl && in_range)           status_o = ST_FIXED;
    else if (cmpl)                       status_o = ST_BAD;
    else if ((diff & (diff - 1'b1)) == 24'h0) status_o = ST_CODE;
    else                                 status_o = ST_BAD;
  end

  assign err_off_o = (status_o == ST_FIXED) ? diff[23:15] : '0;
  assign err_bit_o = (status_o == ST_FIXED) ? diff[14:12] : '0;
endmodule

module sector_hamming_ecc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] stored_code_i,
  input logic [23:0] code_o,
  input logic        done_o,
  input logic [1:0]  status_o,
  input logic [8:0]  err_off_o,
  input logic [2:0]  err_bit_o
);
  logic [23:0] d;
  assign d = stored_code_i ^ code_o;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R1
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(code_o)); // R1
  AST_MATCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (d == 24'h0) |-> status_o == 2'd0); // R4
  AST_FIX_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n) (status_o == 2'd1) |-> (d[23:12] == ~d[11:0])); // R5
  AST_LOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (status_o != 2'd1) |-> (err_off_o == 9'd0 && err_bit_o == 3'd0)); // R5
  AST_CODE_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n) (status_o == 2'd2) |-> $countones(d) == 1); // R6
endmodule

bind sector_hamming_ecc sector_hamming_ecc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stored_code_i(stored_code_i), .code_o(code_o),
  .done_o(done_o), .status_o(status_o), .err_off_o(err_off_o), .err_bit_o(err_bit_o)
);

// File: tb/sector_hamming_ecc_tb.sv
module sector_hamming_ecc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, vld = 1'b0;
  logic [7:0] din = 8'h00;
  logic [23:0] stored = 24'h0, stored_s = 24'h0;
  logic [23:0] code, code_s;
  logic done, done_s;
  logic [1:0] status, status_s;
  logic [8:0] off, off_s;
  logic [2:0] bitx, bitx_s;
  logic [7:0] sec [0:511];
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sector_hamming_ecc u_dut (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(din),
    .stored_code_i(stored), .code_o(code), .done_o(done), .status_o(status),
    .err_off_o(off), .err_bit_o(bitx));

  sector_hamming_ecc #(.SECTOR_BYTES(500)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(vld), .byte_i(din),
    .stored_code_i(stored_s), .code_o(code_s), .done_o(done_s), .status_o(status_s),
    .err_off_o(off_s), .err_bit_o(bitx_s));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(input int n);
    logic [11:0] h = 12'h0, l = 12'h0;
    for (int a = 0; a < n; a++)
      for (int b = 0; b < 8; b++)
        if (sec[a][b]) begin
          h ^= {9'(a), 3'(b)};
          l ^= ~{9'(a), 3'(b)};
        end
    return ~{h, l};
  endfunction

  function automatic logic [23:0] loc_diff(input int a, input int b);
    return {9'(a), 3'(b), ~{9'(a), 3'(b)}};
  endfunction

  task automatic fill(input int kind);
    logic [7:0] s = 8'h5A;
    for (int i = 0; i < 512; i++) begin
      case (kind)
        0: sec[i] = 8'hFF;
        1: sec[i] = 8'(i * 7 + 3);
        default: begin
          s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
          sec[i] = s;
        end
      endcase
    end
  endtask

  task automatic feed(input bit gaps);
    for (int i = 0; i < 512; i++) begin
      if (gaps && (i % 37 == 5)) begin
        @(negedge clk); sof = 1'b0; vld = 1'b0; din = 8'hC3;
      end
      @(negedge clk);
      sof = (i == 0); vld = 1'b1; din = sec[i];
    end
    @(negedge clk); sof = 1'b0; vld = 1'b0; din = 8'h00;
    chk(done == 1'b1, "R1 done after last byte", 32'(done), 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R1 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R10 reset done", 32'(done), 32'd0);
    chk(code == 24'hFFFFFF, "R10 reset code", 32'(code), 32'hFFFFFF);
  endtask

  task automatic t_erased;
    fill(0); feed(1'b0);
    chk(code == 24'hFFFFFF, "R3 erased code", 32'(code), 32'hFFFFFF);
    stored = 24'hFFFFFF; #1;
    chk(status == 2'd0, "R3 erased checks clean", 32'(status), 32'd0);
  endtask

  task automatic t_patterns;
    logic [23:0] e;
    fill(1); feed(1'b0); e = model(512);
    chk(code == e, "R2 code ramp sector", 32'(code), 32'(e));
    chk(code[7:0] == e[7:0], "R2 first stored byte in bits 7:0", 32'(code[7:0]), 32'(e[7:0]));
    fill(2); feed(1'b1); e = model(512);
    chk(code == e, "R9 R2 code with idle gaps", 32'(code), 32'(e));
    repeat (3) @(negedge clk);
    chk(code == e, "R1 code holds between sectors", 32'(code), 32'(e));
  endtask

  task automatic t_clean;
    stored = code; #1;
    chk(status == 2'd0, "R4 equal codes clean", 32'(status), 32'd0);
    chk(off == 9'd0 && bitx == 3'd0, "R5 location zero when clean", 32'({off, bitx}), 32'd0);
  endtask

  task automatic t_data_bit(input int a, input int b);
    logic [23:0] good;
    good = model(512);
    sec[a][b] = ~sec[a][b];
    feed(1'b0);
    stored = good; #1;
    chk(status == 2'd1, "R5 single data bit status", 32'(status), 32'd1);
    chk(off == 9'(a), "R5 error offset", 32'(off), 32'(a));
    chk(bitx == 3'(b), "R5 error bit index", 32'(bitx), 32'(b));
    sec[a][b] = ~sec[a][b];
  endtask

  task automatic t_code_bit;
    stored = code ^ 24'h000400; #1;
    chk(status == 2'd2, "R6 single bit in stored code", 32'(status), 32'd2);
    stored = code ^ 24'h800000; #1;
    chk(status == 2'd2, "R6 top bit in stored code", 32'(status), 32'd2);
    chk(off == 9'd0 && bitx == 3'd0, "R5 location zero on code error", 32'({off, bitx}), 32'd0);
  endtask

  task automatic t_multi;
    stored = code ^ loc_diff(3, 1) ^ loc_diff(200, 6); #1;
    chk(status == 2'd3, "R7 two data bits uncorrectable", 32'(status), 32'd3);
    stored = code ^ 24'h000003; #1;
    chk(status == 2'd3, "R7 two code bits uncorrectable", 32'(status), 32'd3);
  endtask

  task automatic t_range;
    fill(1); feed(1'b0);
    stored_s = code_s ^ loc_diff(505, 2); #1;
    chk(status_s == 2'd3, "R8 offset beyond short sector", 32'(status_s), 32'd3);
    stored_s = code_s ^ loc_diff(499, 4); #1;
    chk(status_s == 2'd1 && off_s == 9'd499, "R8 last in-range offset", 32'({status_s, off_s}), 32'({2'd1, 9'd499}));
  endtask

  task automatic t_restart;
    logic [23:0] e;
    fill(2);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); sof = (i == 0); vld = 1'b1; din = 8'(i ^ 8'h3C);
    end
    chk(done == 1'b0, "R9 no done on partial sector", 32'(done), 32'd0);
    feed(1'b0); e = model(512);
    chk(code == e, "R9 sof restarts accumulation", 32'(code), 32'(e));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_erased;
        t_patterns;
        t_clean;
        fill(2);
        t_data_bit(0, 0);
        t_data_bit(511, 7);
        t_data_bit(257, 3);
        t_code_bit;
        t_multi;
        t_range;
        t_restart;
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule